// File: doc/BRIEF.md
# Stop-Clock Grant Controller

This block sits on the processor side of a low-power request pin. System logic drives an active-low stop-clock request that has no timing relationship to the local bus clock. The controller brings that request into the clock domain and, when it sees the request, asks the bus interface to issue one grant acknowledge transaction. Only after the bus interface confirms that the transaction went out does it lower the clock enables of the core units. The enables for the bus interface and the interrupt controller stay high throughout, so snooping and interrupt service keep working while the core is stopped.

When the request is released, the controller passes through a short resume phase and then raises every core enable again so that execution continues. The bus clock itself is never touched. Only enables are produced; the clock gating cells and the encoding of the bus transaction belong to neighbouring blocks.

The acknowledge interface is a valid/ready handshake. `ack_req` acts as valid and `ack_done` acts as ready, and one transfer happens on a rising edge where both are high. The bus interface may hold `ack_done` low for as long as it needs to. During that time `ack_req` stays high and the core keeps running. `ack_done` has no effect while `ack_req` is low.

Top module: `stop_clock_ctrl`

## Requirements
- R1: After reset, every bit of `core_clk_en` is 1, `bus_clk_en` and `apic_clk_en` are 1, and `ack_req` and `stop_grant` are 0.
- R2: `stpclk_n` is active low and passes through a two-flop synchronizer. If it is low before a rising edge, `ack_req` is 0 after the second rising edge and 1 after the third. Each assertion of the request produces exactly one acknowledge transfer.
- R3: Once `ack_req` is high, it stays high until a rising edge where `ack_done` is 1. Until that edge, every bit of `core_clk_en` stays 1.
- R4: If the synchronized request is still active at the edge where the acknowledge transfer happens, then from that edge `ack_req` is 0, every bit of `core_clk_en` is 0, and `stop_grant` is 1.
- R5: `bus_clk_en` and `apic_clk_en` remain 1 in every state after reset, including while `stop_grant` is 1.
- R6: While `stop_grant` is 1, `ack_done` has no effect: `stop_grant` stays 1, `core_clk_en` stays 0, and `ack_req` stays 0 for as long as the request is held.
- R7: If the request is released before the transfer completes, `ack_req` stays high until `ack_done`. At that edge the block returns straight to run, `ack_req` goes to 0, and `core_clk_en` is never lowered.
- R8: After `stpclk_n` returns high while granted, `stop_grant` falls at the third rising edge. `core_clk_en` stays 0 for exactly one further cycle (the resume phase) and then returns to all ones.
- R9: `ack_done` pulses while the block is running and no acknowledge is pending have no effect: `ack_req` stays 0 and `core_clk_en` stays all ones.
- R10: A request that is reasserted during the resume phase does not shorten it. The block enters run with the core enables restored, and only then starts a new acknowledge, following the R2 latency from the reassertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| stpclk_n | input | 1 | Active-low stop-clock request, asynchronous to clk |
| ack_req | output | 1 | Valid of the grant acknowledge handshake |
| ack_done | input | 1 | Ready of the grant acknowledge handshake |
| core_clk_en | output | NUM_CORE_UNITS (4) | Clock enables for the core units, 1 = running |
| bus_clk_en | output | 1 | Clock enable for the bus interface unit |
| apic_clk_en | output | 1 | Clock enable for the interrupt controller unit |
| stop_grant | output | 1 | High while the core is in the low-power grant state |

## Verification
The assertions assume that `ack_done` comes from a bus interface that answers a pending request in its own time. They rely on the acknowledge handshake alone, and not on any limit on how long `ack_done` may be withheld or on how often the request toggles. They also assume that `stpclk_n` is stable long enough for the synchronizer to capture it. The bench changes `stpclk_n` and `ack_done` only on falling clock edges and holds each level for several cycles. It raises `ack_done` both while a request is pending and at times when nothing is pending, so that the cases where it should be ignored are exercised inside those assumptions.

// File: rtl/stop_clock_pkg.sv
package stop_clock_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_SEND_ACK = 2'd1,
    ST_GRANT    = 2'd2,
    ST_RESUME   = 2'd3
  } sc_state_e;
endpackage

// File: rtl/stop_clock_sync.sv
// Multi-stage synchronizer for the asynchronous active-low request.
// The chain resets to the inactive (high) level; the output is active high.
module stop_clock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic req_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign req_sync = ~chain_q[STAGES-1];
endmodule

// File: rtl/stop_clock_fsm.sv
// Sequencer: run -> send acknowledge -> grant -> resume -> run.
module stop_clock_fsm
  import stop_clock_pkg::*;
#(
  parameter int RESUME_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_sync,
  input  logic      ack_done,
  output logic      ack_req,
  output sc_state_e state
);
  localparam int CW = (RESUME_CYCLES > 1) ? $clog2(RESUME_CYCLES) : 1;
  localparam logic [CW-1:0] RES_LAST = CW'(RESUME_CYCLES - 1);

  sc_state_e state_q, state_d;
  logic [CW-1:0] res_cnt_q, res_cnt_d;
  logic          xfer;

  // One handshake transfer: valid and ready high together.
  assign xfer = (state_q == ST_SEND_ACK) && ack_done;

  always_comb begin
    state_d   = state_q;
    res_cnt_d = res_cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (req_sync) state_d = ST_SEND_ACK;
      end
      ST_SEND_ACK: begin
        if (xfer) state_d = req_sync ? ST_GRANT : ST_RUN;
      end
      ST_GRANT: begin
        if (!req_sync) begin
          state_d   = ST_RESUME;
          res_cnt_d = '0;
        end
      end
      ST_RESUME: begin
        if (res_cnt_q == RES_LAST) state_d = ST_RUN;
        else                       res_cnt_d = res_cnt_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      res_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      res_cnt_q <= res_cnt_d;
    end
  end

  assign ack_req = (state_q == ST_SEND_ACK);
  assign state   = state_q;
endmodule

// File: rtl/stop_clock_enables.sv
// Decodes the sequencer state into per-unit clock enables.
module stop_clock_enables
  import stop_clock_pkg::*;
#(
  parameter int NUM_CORE_UNITS = 4
) (
  input  sc_state_e                 state,
  output logic [NUM_CORE_UNITS-1:0] core_clk_en,
  output logic                      bus_clk_en,
  output logic                      apic_clk_en,
  output logic                      stop_grant
);
  logic core_run;

  assign core_run = (state == ST_RUN) || (state == ST_SEND_ACK);

  generate
    for (genvar u = 0; u < NUM_CORE_UNITS; u++) begin : g_core
      assign core_clk_en[u] = core_run;
    end
  endgenerate

  // Bus and interrupt units keep running in every state.
  assign bus_clk_en  = 1'b1;
  assign apic_clk_en = 1'b1;
  assign stop_grant  = (state == ST_GRANT);
endmodule

// File: rtl/stop_clock_ctrl.sv
module stop_clock_ctrl
  import stop_clock_pkg::*;
#(
  parameter int NUM_CORE_UNITS = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int RESUME_CYCLES  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stpclk_n,
  output logic                      ack_req,
  input  logic                      ack_done,
  output logic [NUM_CORE_UNITS-1:0] core_clk_en,
  output logic                      bus_clk_en,
  output logic                      apic_clk_en,
  output logic                      stop_grant
);
  logic      req_sync;
  sc_state_e state;

  stop_clock_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_n  (stpclk_n),
    .req_sync (req_sync)
  );

  stop_clock_fsm #(.RESUME_CYCLES(RESUME_CYCLES)) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_sync (req_sync),
    .ack_done (ack_done),
    .ack_req  (ack_req),
    .state    (state)
  );

  stop_clock_enables #(.NUM_CORE_UNITS(NUM_CORE_UNITS)) en_i (
    .state       (state),
    .core_clk_en (core_clk_en),
    .bus_clk_en  (bus_clk_en),
    .apic_clk_en (apic_clk_en),
    .stop_grant  (stop_grant)
  );
endmodule

// File: rtl/stop_clock_ctrl_chk.sv
module stop_clock_ctrl_chk #(
  parameter int NUM_CORE_UNITS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ack_req,
  input logic                      ack_done,
  input logic [NUM_CORE_UNITS-1:0] core_clk_en,
  input logic                      bus_clk_en,
  input logic                      apic_clk_en,
  input logic                      stop_grant
);
  // R3: a pending acknowledge is held until it is accepted
  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_done) |=> ack_req);

  // R3: core enables stay on while the acknowledge is pending
  a_r3_core_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (&core_clk_en));

  // R4: the core stops only directly after an accepted acknowledge
  a_r4_stop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en[0]) |-> $past(ack_req && ack_done));

  // R4: grant state always has every core enable low
  a_r4_grant_core_off: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> (core_clk_en == '0));

  // R5: bus and interrupt units run during grant
  a_r5_bus_apic_on: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> (bus_clk_en && apic_clk_en));

  // R6: no new acknowledge while granted
  a_r6_no_ack_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> !ack_req);

  // R8: core enables never return straight out of grant
  a_r8_resume_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en[0]) |-> !$past(stop_grant));

  // R4: core enables move together
  a_r4_core_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en == '0) || (&core_clk_en));
endmodule

bind stop_clock_ctrl stop_clock_ctrl_chk #(.NUM_CORE_UNITS(NUM_CORE_UNITS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_req     (ack_req),
  .ack_done    (ack_done),
  .core_clk_en (core_clk_en),
  .bus_clk_en  (bus_clk_en),
  .apic_clk_en (apic_clk_en),
  .stop_grant  (stop_grant)
);

// File: tb/stop_clock_ctrl_tb_top.sv
`timescale 1ns/1ps
module stop_clock_ctrl_tb_top;
  localparam int NU = 4;
  localparam logic [NU-1:0] ALL_ON = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stpclk_n = 1'b1;
  logic          ack_done = 1'b0;
  logic          ack_req, bus_clk_en, apic_clk_en, stop_grant;
  logic [NU-1:0] core_clk_en;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  stop_clock_ctrl #(.NUM_CORE_UNITS(NU)) dut_i (
    .clk(clk), .rst_n(rst_n), .stpclk_n(stpclk_n), .ack_req(ack_req),
    .ack_done(ack_done), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .apic_clk_en(apic_clk_en), .stop_grant(stop_grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic side_units(input string tag);
    chk({tag, " bus_clk_en"}, 32'(bus_clk_en), 1);
    chk({tag, " apic_clk_en"}, 32'(apic_clk_en), 1);
  endtask

  // Drives the request low and completes the acknowledge to reach grant.
  task automatic go_grant();
    stpclk_n = 1'b0;
    cyc(3);
    ack_done = 1'b1;
    cyc(1);
    ack_done = 1'b0;
  endtask

  // Releases the request from grant and waits until run is reached.
  task automatic leave_grant();
    stpclk_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R1 core_clk_en", 32'(core_clk_en), 32'(ALL_ON));
    chk("R1 ack_req", 32'(ack_req), 0);
    chk("R1 stop_grant", 32'(stop_grant), 0);
    side_units("R1");
  endtask

  task automatic t_basic();
    stpclk_n = 1'b0;
    cyc(2);
    chk("R2 ack_req after 2 edges", 32'(ack_req), 0);
    cyc(1);
    chk("R2 ack_req after 3 edges", 32'(ack_req), 1);
    for (int i = 0; i < 3; i++) begin
      cyc(1);
      chk("R3 ack_req held", 32'(ack_req), 1);
      chk("R3 core on while pending", 32'(core_clk_en), 32'(ALL_ON));
    end
    ack_done = 1'b1;
    cyc(1);
    ack_done = 1'b0;
    chk("R4 core off", 32'(core_clk_en), 0);
    chk("R4 stop_grant", 32'(stop_grant), 1);
    chk("R4 ack_req low", 32'(ack_req), 0);
    side_units("R5 grant");
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      chk("R2 single ack", 32'(ack_req), 0);
    end
    stpclk_n = 1'b1;
    cyc(2);
    chk("R8 still granted", 32'(stop_grant), 1);
    cyc(1);
    chk("R8 grant dropped", 32'(stop_grant), 0);
    chk("R8 core off in resume", 32'(core_clk_en), 0);
    side_units("R5 resume");
    cyc(1);
    chk("R8 core restored", 32'(core_clk_en), 32'(ALL_ON));
  endtask

  task automatic t_withdraw();
    stpclk_n = 1'b0;
    cyc(3);
    chk("R7 ack_req raised", 32'(ack_req), 1);
    stpclk_n = 1'b1;
    cyc(3);
    chk("R7 ack held after withdraw", 32'(ack_req), 1);
    chk("R7 core on", 32'(core_clk_en), 32'(ALL_ON));
    ack_done = 1'b1;
    cyc(1);
    ack_done = 1'b0;
    chk("R7 ack_req low", 32'(ack_req), 0);
    chk("R7 core never off", 32'(core_clk_en), 32'(ALL_ON));
    chk("R7 no grant", 32'(stop_grant), 0);
    cyc(4);
    chk("R7 stays run", 32'(ack_req), 0);
  endtask

  task automatic t_stray();
    ack_done = 1'b1;
    cyc(3);
    chk("R9 ack_req idle", 32'(ack_req), 0);
    chk("R9 core on", 32'(core_clk_en), 32'(ALL_ON));
    chk("R9 no grant", 32'(stop_grant), 0);
    ack_done = 1'b0;
    cyc(1);
    go_grant();
    ack_done = 1'b1;
    cyc(3);
    ack_done = 1'b0;
    chk("R6 grant kept", 32'(stop_grant), 1);
    chk("R6 core off", 32'(core_clk_en), 0);
    chk("R6 no ack", 32'(ack_req), 0);
    leave_grant();
    chk("R6 exit normal", 32'(core_clk_en), 32'(ALL_ON));
  endtask

  task automatic t_reassert();
    go_grant();
    stpclk_n = 1'b1;
    cyc(3);
    chk("R10 in resume", 32'(core_clk_en), 0);
    stpclk_n = 1'b0;
    cyc(1);
    chk("R10 run reached", 32'(core_clk_en), 32'(ALL_ON));
    chk("R10 no early ack", 32'(ack_req), 0);
    cyc(1);
    chk("R10 ack not yet", 32'(ack_req), 0);
    cyc(1);
    chk("R10 new ack", 32'(ack_req), 1);
    ack_done = 1'b1;
    cyc(1);
    ack_done = 1'b0;
    chk("R10 grant again", 32'(stop_grant), 1);
    leave_grant();
    chk("R10 final run", 32'(core_clk_en), 32'(ALL_ON));
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_basic();
    cyc(2);
    t_withdraw();
    cyc(2);
    t_stray();
    cyc(2);
    t_reassert();
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule